// File: doc/BRIEF.md
# Direct-Mapped Four-Word-Line Cache Controller

This block sits between a processor word port and a slower main memory that moves whole 128-bit blocks. It keeps 4096 lines. Each line has a valid flag, a 16-bit stored tag and four 32-bit words. Every memory block has exactly one home line: the block address modulo the line count. A lookup compares the stored tag with the upper address bits and checks the valid flag. The low address bits then pick one word out of the line.

A read hit finishes in the cycle it is presented, with no stall. A read miss raises the stall output and fetches the whole block over the memory port. It fills the line, and the access then repeats its lookup and finishes as a hit. Writes are write-through with allocation. A write to an absent line first refills that line, then merges the new word into the cache, then sends the word to memory. The stall stays high until memory acknowledges the write.

The processor must hold its request, address, write flag and write data steady while stall is high. It may change them in the cycle after stall is seen low. Only word-aligned 32-bit accesses are supported.

Top module: `dm_cache_ctrl`

## Requirements
- R1: After reset is released every line is invalid, so the first access to any line is a miss and causes exactly one block read on the memory port.
- R2: The 32-bit address splits as tag = bits 31..16, line index = bits 15..4, word select = bits 3..2 and byte bits 1..0. hit_o is high only when cpu_req_i is high, the controller is in its lookup state, the indexed line is valid and its stored tag equals bits 31..16.
- R3: A read hit drives cpu_rdata_o with the selected word in the same cycle and keeps stall_o low. It issues no memory request.
- R4: A read miss keeps stall_o high and requests the block at the address with bits 3..0 cleared (mem_we_o low). Word k of mem_rdata_i is bits 32k+31..32k. In the cycle after mem_ready_i the same access looks up again and hits, returning the fetched word.
- R5: A write hit updates the word in the line and requests a memory write with mem_addr_o = address with bits 1..0 cleared and mem_wdata_o = cpu_wdata_i. stall_o stays high until the cycle where mem_ready_i is high, and in that cycle it is low.
- R6: A write miss first reads the whole block (one memory read), then merges the written word into the line, then performs the write-through (one memory write). A later read of that line hits and returns the merged word alongside the fetched words.
- R7: Two blocks with the same index and different tags share one line: fetching one evicts the other, so the next access to the evicted block misses again.
- R8: Byte bits 1..0 of the address are ignored. Addresses that differ only there hit the same word and return the same data.
- R9: Once raised, mem_req_o, mem_addr_o and mem_we_o hold steady until the cycle in which mem_ready_i is high.
- R10: With cpu_req_i low and no memory transfer pending, stall_o and mem_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Processor access request |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 32 | Byte address |
| cpu_wdata_i | input | 32 | Write word |
| cpu_rdata_o | output | 32 | Word selected from the indexed line |
| stall_o | output | 1 | Access not yet complete |
| hit_o | output | 1 | Lookup hit for the current request |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | 1 = word write-through, 0 = block read |
| mem_addr_o | output | 32 | Block address (read) or word address (write) |
| mem_wdata_o | output | 32 | Write-through word |
| mem_rdata_i | input | 128 | Fetched block |
| mem_ready_i | input | 1 | Memory completes the transfer this cycle |

## Verification
A stale valid flag or a wrong stored tag shows up at hit_o in the first cycle of the next access to that line. It also shows up as a block read appearing or missing on the memory port before the access finishes. A word merged at the wrong position, or a refill placed in the wrong line, appears as a wrong cpu_rdata_o on the next read hit of that line. The bench compares that value with its own model of memory. A stuck controller state shows up as stall_o held high, or as a memory request that never drops, within a few cycles of the transfer.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_LOOKUP = 2'd0,
    ST_REFILL = 2'd1,
    ST_WTHRU  = 2'd2
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int LINES = 4096,
  parameter int TAG_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[wr_idx_i] <= wr_tag_i;
  end

  assign valid_o = valid_q[rd_idx_i];
  assign tag_o   = tag_q[rd_idx_i];
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int LINES  = 4096,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFS_W  = $clog2(WORDS),
  localparam int LINE_W = WORD_W * WORDS
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              fill_en_i,
  input  logic [LINE_W-1:0] fill_line_i,
  input  logic              word_wr_en_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  logic [LINE_W-1:0] line_q [LINES];
  logic [LINE_W-1:0] cur_line;

  always_ff @(posedge clk_i) begin
    if (fill_en_i) line_q[idx_i] <= fill_line_i;
    else if (word_wr_en_i) line_q[idx_i][ofs_i*WORD_W +: WORD_W] <= word_i;
  end

  assign cur_line = line_q[idx_i];

  // word-select multiplexer
  always_comb begin
    word_o = '0;
    for (int k = 0; k < WORDS; k++) begin
      if (ofs_i == OFS_W'(k)) word_o = cur_line[k*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/dmc_fsm.sv
module dmc_fsm
  import dmc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic we_i,
  input  logic tag_hit_i,
  input  logic mem_ready_i,
  output logic lookup_o,
  output logic fill_en_o,
  output logic word_wr_en_o,
  output logic mem_req_o,
  output logic mem_we_o,
  output logic stall_o
);
  dmc_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_LOOKUP;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d      = state_q;
    lookup_o     = 1'b0;
    fill_en_o    = 1'b0;
    word_wr_en_o = 1'b0;
    mem_req_o    = 1'b0;
    mem_we_o     = 1'b0;
    stall_o      = 1'b0;
    unique case (state_q)
      ST_LOOKUP: begin
        lookup_o = 1'b1;
        if (req_i) begin
          if (!tag_hit_i) begin
            stall_o = 1'b1;
            state_d = ST_REFILL;
          end else if (we_i) begin
            stall_o      = 1'b1;
            word_wr_en_o = 1'b1;
            state_d      = ST_WTHRU;
          end
        end
      end
      ST_REFILL: begin
        mem_req_o = 1'b1;
        stall_o   = 1'b1;
        if (mem_ready_i) begin
          fill_en_o = 1'b1;
          state_d   = ST_LOOKUP;  // replay the access
        end
      end
      ST_WTHRU: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        stall_o   = !mem_ready_i;
        if (mem_ready_i) state_d = ST_LOOKUP;
      end
      default: state_d = ST_LOOKUP;
    endcase
  end
endmodule

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int LINES  = 4096,
  localparam int BYTE_W = $clog2(WORD_W / 8),
  localparam int OFS_W  = $clog2(WORDS),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFS_W - BYTE_W,
  localparam int LINE_W = WORD_W * WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [WORD_W-1:0] cpu_wdata_i,
  output logic [WORD_W-1:0] cpu_rdata_o,
  output logic              stall_o,
  output logic              hit_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [LINE_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i
);
  logic [TAG_W-1:0] a_tag, st_tag;
  logic [IDX_W-1:0] a_idx;
  logic [OFS_W-1:0] a_ofs;
  logic             byte_bits_unused;
  logic             st_valid, tag_hit, lookup, fill_en, word_wr_en;

  assign a_tag = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign a_idx = cpu_addr_i[BYTE_W+OFS_W +: IDX_W];
  assign a_ofs = cpu_addr_i[BYTE_W +: OFS_W];
  assign byte_bits_unused = ^cpu_addr_i[BYTE_W-1:0];

  dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (a_idx),
    .wr_en_i  (fill_en),
    .wr_idx_i (a_idx),
    .wr_tag_i (a_tag),
    .valid_o  (st_valid),
    .tag_o    (st_tag)
  );

  dmc_data_store #(.LINES(LINES), .WORD_W(WORD_W), .WORDS(WORDS)) u_data (
    .clk_i        (clk_i),
    .idx_i        (a_idx),
    .ofs_i        (a_ofs),
    .fill_en_i    (fill_en),
    .fill_line_i  (mem_rdata_i),
    .word_wr_en_i (word_wr_en),
    .word_i       (cpu_wdata_i),
    .word_o       (cpu_rdata_o)
  );

  assign tag_hit = st_valid && (st_tag == a_tag);

  dmc_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (cpu_req_i),
    .we_i         (cpu_we_i),
    .tag_hit_i    (tag_hit),
    .mem_ready_i  (mem_ready_i),
    .lookup_o     (lookup),
    .fill_en_o    (fill_en),
    .word_wr_en_o (word_wr_en),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .stall_o      (stall_o)
  );

  assign hit_o = lookup && cpu_req_i && tag_hit;

  // block address for refill, word address for write-through
  always_comb begin
    if (mem_we_o) mem_addr_o = {cpu_addr_i[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
    else          mem_addr_o = {cpu_addr_i[ADDR_W-1:BYTE_W+OFS_W], {(BYTE_W+OFS_W){1'b0}}};
  end
  assign mem_wdata_o = cpu_wdata_i;
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              stall_o,
  input logic              hit_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ready_i
);
  assert_read_hit_fast_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && hit_o && !cpu_we_i |-> !stall_o && !mem_req_o);

  assert_miss_stalls_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && !hit_o && !mem_req_o |-> stall_o);

  assert_replay_hits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && mem_ready_i |=> !(cpu_req_i && $stable(cpu_addr_i)) || hit_o);

  assert_write_hit_thru_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_we_i && hit_o |=> mem_req_o && mem_we_o && stall_o == !mem_ready_i);

  assert_req_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_req_i && !mem_req_o |-> !stall_o);
endmodule

bind dm_cache_ctrl dmc_checker #(.ADDR_W(ADDR_W)) u_dmc_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_req_i   (cpu_req_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_addr_i  (cpu_addr_i),
  .stall_o     (stall_o),
  .hit_o       (hit_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ready_i (mem_ready_i)
);

// File: tb/sim_dm_cache_ctrl.sv
`timescale 1ns/1ps
module sim_dm_cache_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0, we = 1'b0;
  logic [31:0]  addr = '0, wdata = '0;
  logic [31:0]  rdata, mem_addr, mem_wdata;
  logic         stall, hit, mem_req, mem_we;
  logic [127:0] mem_rdata = '0;
  logic         mem_ready = 1'b0;

  int total = 0, bad = 0;
  int rd_cnt = 0, wr_cnt = 0, lat = 1, wait_cnt = 0;
  bit hs_err = 0, prev_wait = 0, done = 0;
  logic [31:0] prev_addr;
  logic        prev_we;
  logic [31:0] ref_mem [logic [31:0]];

  always #5 clk = ~clk;

  dm_cache_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(req), .cpu_we_i(we),
    .cpu_addr_i(addr), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata),
    .stall_o(stall), .hit_o(hit), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ready_i(mem_ready)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] w = {a[31:2], 2'b00};
    if (ref_mem.exists(w)) return ref_mem[w];
    return {w[15:0] ^ 16'h5A3C, w[31:16] + 16'h1111};
  endfunction

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  // memory model
  initial forever begin
    @(negedge clk);
    mem_ready = 1'b0;
    if (mem_req) begin
      if (prev_wait && (mem_addr !== prev_addr || mem_we !== prev_we)) hs_err = 1;
      if (wait_cnt >= lat) begin
        mem_ready = 1'b1;
        wait_cnt = 0;
        prev_wait = 0;
        if (mem_we) begin
          ref_mem[mem_addr] = mem_wdata;
          wr_cnt++;
        end else begin
          for (int k = 0; k < 4; k++) mem_rdata[32*k +: 32] = mem_word(mem_addr + 32'(4*k));
          rd_cnt++;
        end
      end else begin
        wait_cnt++;
        prev_wait = 1;
        prev_addr = mem_addr;
        prev_we = mem_we;
      end
    end else begin
      wait_cnt = 0;
      prev_wait = 0;
    end
  end

  task automatic access(input logic w, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic first_hit,
                        output int nrd, output int nwr);
    int r0, w0, guard;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    r0 = rd_cnt; w0 = wr_cnt;
    #1 first_hit = hit;
    guard = 0;
    while (stall && guard < 1000) begin
      @(negedge clk); #1;
      guard++;
    end
    if (guard >= 1000) chk("R9 access hung", 32'(guard), 32'd0);
    rd = rdata;
    @(posedge clk); #1;
    req = 1'b0;
    nrd = rd_cnt - r0; nwr = wr_cnt - w0;
  endtask

  typedef struct packed {
    logic        w;
    logic [31:0] a;
    logic [31:0] d;
    logic        hit;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h0001_0010, 32'h0,         1'b0},  // R1 R4 cold miss
    '{1'b0, 32'h0001_001C, 32'h0,         1'b1},  // R3 word 3 same line
    '{1'b0, 32'h0001_0017, 32'h0,         1'b1},  // R8 byte bits set
    '{1'b1, 32'h0001_0018, 32'hDEAD_0001, 1'b1},  // R5 write hit
    '{1'b0, 32'h0001_0018, 32'h0,         1'b1},  // R5 read back
    '{1'b0, 32'h0002_0010, 32'h0,         1'b0},  // R7 same index, other tag
    '{1'b0, 32'h0001_0010, 32'h0,         1'b0},  // R7 evicted block misses
    '{1'b1, 32'h0003_0024, 32'h1234_ABCD, 1'b0},  // R6 write miss
    '{1'b0, 32'h0003_0024, 32'h0,         1'b1},  // R6 merged word
    '{1'b0, 32'h0003_002C, 32'h0,         1'b1},  // R6 fetched neighbour
    '{1'b0, 32'hFFFF_FFF0, 32'h0,         1'b0},  // R2 top index miss
    '{1'b0, 32'hFFFF_FFFC, 32'h0,         1'b1}   // R2 top index hit
  };

  initial begin
    logic [31:0] rd, exp;
    logic fh;
    int nrd, nwr;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 stall in reset", 32'(stall), 32'd0);
    chk("R10 mem_req in reset", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R10 idle stall", 32'(stall), 32'd0);
    chk("R10 idle mem_req", 32'(mem_req), 32'd0);

    for (int i = 0; i < NV; i++) begin
      lat = i % 3;
      exp = mem_word(VEC[i].a);
      access(VEC[i].w, VEC[i].a, VEC[i].d, rd, fh, nrd, nwr);
      chk($sformatf("R2 hit flag vec%0d", i), 32'(fh), 32'(VEC[i].hit));
      chk($sformatf("R4 block reads vec%0d", i), 32'(nrd), VEC[i].hit ? 32'd0 : 32'd1);
      chk($sformatf("R5 R6 word writes vec%0d", i), 32'(nwr), VEC[i].w ? 32'd1 : 32'd0);
      if (!VEC[i].w) chk($sformatf("R3 R4 read data vec%0d", i), rd, exp);
    end
    chk("R5 write-through reached memory", mem_word(32'h0001_0018), 32'hDEAD_0001);
    chk("R6 write-miss word in memory", mem_word(32'h0003_0024), 32'h1234_ABCD);
    chk("R8 byte bits ignored", mem_word(32'h0001_0017), mem_word(32'h0001_0014));
    chk("R9 request held until ready", 32'(hs_err), 32'd0);

    // R1: reset again invalidates lines
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    exp = mem_word(32'h0003_0024);
    access(1'b0, 32'h0003_0024, 32'h0, rd, fh, nrd, nwr);
    chk("R1 miss after reset", 32'(fh), 32'd0);
    chk("R1 one refill after reset", 32'(nrd), 32'd1);
    chk("R1 data after reset", rd, exp);
    @(negedge clk); #1;
    chk("R10 quiet after access", 32'(stall | mem_req), 32'd0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) chk("watchdog expired", 32'd1, 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule